// File: doc/BRIEF.md
# Programmable Interval Timer with Read Snapshot

This block is a 32-bit down-counting interval timer that sits on a simple single-cycle register bus. Software programs a reload value, picks one of four count rates, and starts the counter. Each time the count runs out, the timer reloads itself and raises an interrupt flag. That flag drives a level interrupt output, gated by an enable bit. Software clears the flag through a dedicated clear register or by writing the flag bit as zero. Writing the flag bit as one forces a single interrupt.

The count rate comes from a 4 MHz reference tick, supplied as a single-cycle pulse in the system clock domain. A prescaler turns that tick into 2, 1, 0.5 or 0.25 MHz count enables. No derived clock is created, so the whole block runs on one clock.

Reading the live count takes two steps. Software first reads a trigger address, which copies the counter into a holding register. It then reads the value register. A mode bit chooses whether the trigger is the timer's own snapshot address or an address shared with other timers. A read-select bit makes the value register return either the holding register or the programmed reload value.

Top module: `ptmr_top`

Register offsets (byte addresses on `bus_addr`): control/status 0x00, value 0x04, interrupt clear 0x08, own snapshot 0x0C, shared snapshot 0x10.

Control/status layout:
- bit 0: run
- bits 2:1: rate select
- bit 3: read select
- bit 4: snapshot mode
- bit 5: reserved, reads 0
- bit 6: interrupt enable
- bit 7: interrupt flag

## Requirements
- R1: After reset, the counter, reload value, holding register and every control/status bit are 0, `irq` is 0, and reads of the control/status and value registers return 0.
- R2: The rate select field (control bits 2:1) sets the prescaler divisor. Code 00 gives one count tick per 2 reference pulses, 01 per 4, 10 per 8 and 11 per 16. The first tick comes on the divisor-th reference pulse after the run bit is set or the value register is written.
- R3: While the run bit (bit 0) is 1, each count tick decrements the counter when it is above 1. A tick that finds the counter at 1 or 0 is an expiry: the counter reloads with the reload value. While the run bit is 0, the counter holds.
- R4: A write to the value register (0x04) stores the data as the reload value, loads it into the counter, and restarts the prescaler phase from zero.
- R5: When the read select bit (bit 3) is 0, a read of the value register returns the holding register. When it is 1, the read returns the reload value.
- R6: A read of the snapshot trigger address copies the live counter into the holding register. The trigger is 0x0C when the mode bit (bit 4) is 0 and 0x10 when it is 1. A read of the other address leaves the holding register unchanged.
- R7: An expiry sets the interrupt flag (bit 7). The `irq` output is high exactly when the flag and the interrupt enable (bit 6) are both 1.
- R8: The flag clears on any write to the interrupt clear register (0x08), whatever the data, and on a control/status write with bit 7 equal to 0.
- R9: A control/status write with bit 7 equal to 1 sets the flag. With the enable set, this gives one interrupt that stays high until it is cleared and does not repeat after the clear.
- R10: An expiry in the same cycle as a clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | Single-cycle 4 MHz reference pulse |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle `bus_rd` is high |
| irq | output | 1 | Level interrupt request |

## Verification
Assertions check the following on every cycle:
- A count tick only occurs on a reference pulse while the timer runs.
- The counter decrements, reloads on expiry, holds otherwise, and restarts on a value write.
- The prescaler phase clears on restart.
- Expiry wins over a same-cycle clear, and a clear with no set empties the flag.
- The flag never rises without an expiry or a forced set.
- The holding register changes only on a trigger read, and it then takes the live count.

Only the bench scenarios can show the externally visible behaviour:
- the exact reference-pulse counts for each rate code
- the address choice between the own and shared snapshot addresses
- the selection between held count and reload value
- the fact that a forced interrupt does not repeat after it is cleared

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

  // Control fields of the control/status register, bit 6 down to bit 0.
  // The interrupt flag (bit 7) lives in the flag module.
  typedef struct packed {
    logic       ie;     // bit 6 interrupt enable
    logic       rsv;    // bit 5 reserved, reads zero
    logic       lmode;  // bit 4 snapshot trigger mode
    logic       rsel;   // bit 3 value read select
    logic [1:0] csel;   // bits 2:1 rate select
    logic       run;    // bit 0 run
  } ctl_t;

  // Reference pulses per count tick for a rate code.
  function automatic logic [4:0] div_for_sel(input logic [1:0] sel);
    return 5'd2 << sel;
  endfunction

  // Terminal test: a tick at or below one is an expiry.
  function automatic logic at_terminal(input logic [31:0] cnt);
    return cnt <= 32'd1;
  endfunction

endpackage

// File: rtl/ptmr_prescale.sv
module ptmr_prescale
  import ptmr_pkg::*;
#(
  parameter int PW = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic       ref_tick,
  input  logic [1:0] csel,
  output logic       tick
);

  logic [PW-1:0] ph;
  logic [PW:0]   lim;
  logic          wrap;

  assign lim  = (PW+1)'(div_for_sel(csel)) - (PW+1)'(1);
  assign wrap = ({1'b0, ph} >= lim);
  assign tick = run && !restart && ref_tick && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                ph <= '0;
    else if (!run || restart)  ph <= '0;
    else if (ref_tick)         ph <= wrap ? '0 : ph + PW'(1);
  end

  AST_TICK_NEEDS_REF: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (ref_tick && run)); // R2

  AST_PHASE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (ph == '0)); // R4

endmodule

// File: rtl/ptmr_counter.sv
module ptmr_counter
  import ptmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_wr,
  input  logic [CNT_W-1:0] load_data,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] load_val,
  output logic             expire
);

  assign expire = tick && !load_wr && at_terminal(32'(count));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= '0;
      load_val <= '0;
    end else if (load_wr) begin
      count    <= load_data;
      load_val <= load_data;
    end else if (tick) begin
      count    <= expire ? load_val : count - CNT_W'(1);
    end
  end

  AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (count == $past(load_val))); // R3

  AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load_wr && count > CNT_W'(1)) |=> (count == $past(count) - CNT_W'(1))); // R3

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load_wr) |=> $stable(count)); // R3

  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    load_wr |=> (count == $past(load_data) && load_val == $past(load_data))); // R4

endmodule

// File: rtl/ptmr_irqflag.sv
module ptmr_irqflag (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic force_set,
  input  logic clr,
  input  logic ie,
  output logic flag,
  output logic irq
);

  logic set_evt;

  assign set_evt = expire || force_set;
  assign irq     = flag && ie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (set_evt) flag <= 1'b1;
    else if (clr)     flag <= 1'b0;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag); // R10

  AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set_evt) |=> !flag); // R8

  AST_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(set_evt)); // R9

endmodule

// File: rtl/ptmr_top.sv
module ptmr_top
  import ptmr_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int ADDR_W     = 5,
  parameter int PW         = 4,
  parameter int OFS_CSR    = 0,
  parameter int OFS_VAL    = 4,
  parameter int OFS_ICLR   = 8,
  parameter int OFS_OWN    = 12,
  parameter int OFS_SHARED = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq
);

  localparam int CTL_W = $bits(ctl_t);

  ctl_t             ctl_q;
  logic             hit_csr, hit_val, hit_iclr, hit_own, hit_shared;
  logic             wr_csr, wr_val, wr_iclr;
  logic             lat_evt, tick, expire, flag, force_set, clr;
  logic [CNT_W-1:0] count, load_val, hold_q;

  assign hit_csr    = (bus_addr == ADDR_W'(OFS_CSR));
  assign hit_val    = (bus_addr == ADDR_W'(OFS_VAL));
  assign hit_iclr   = (bus_addr == ADDR_W'(OFS_ICLR));
  assign hit_own    = (bus_addr == ADDR_W'(OFS_OWN));
  assign hit_shared = (bus_addr == ADDR_W'(OFS_SHARED));

  assign wr_csr  = bus_wr && hit_csr;
  assign wr_val  = bus_wr && hit_val;
  assign wr_iclr = bus_wr && hit_iclr;

  assign force_set = wr_csr && bus_wdata[CTL_W];
  assign clr       = wr_iclr || (wr_csr && !bus_wdata[CTL_W]);
  assign lat_evt   = bus_rd && (ctl_q.lmode ? hit_shared : hit_own);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (wr_csr) begin
      ctl_q     <= ctl_t'(bus_wdata[CTL_W-1:0]);
      ctl_q.rsv <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (lat_evt) hold_q <= count;
  end

  ptmr_prescale #(.PW(PW)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (ctl_q.run),
    .restart  (wr_val),
    .ref_tick (ref_tick),
    .csel     (ctl_q.csel),
    .tick     (tick)
  );

  ptmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_wr   (wr_val),
    .load_data (bus_wdata),
    .tick      (tick),
    .count     (count),
    .load_val  (load_val),
    .expire    (expire)
  );

  ptmr_irqflag u_flag (
    .clk       (clk),
    .rst_n     (rst_n),
    .expire    (expire),
    .force_set (force_set),
    .clr       (clr),
    .ie        (ctl_q.ie),
    .flag      (flag),
    .irq       (irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (hit_csr)      bus_rdata = CNT_W'({flag, ctl_q});
      else if (hit_val) bus_rdata = ctl_q.rsel ? load_val : hold_q;
    end
  end

  AST_LATCH_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    lat_evt |=> (hold_q == $past(count))); // R6

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !lat_evt |=> $stable(hold_q)); // R6

endmodule

// File: tb/ptmr_top_tb_top.sv
module ptmr_top_tb_top;

  localparam logic [4:0] A_CSR = 5'd0, A_VAL = 5'd4, A_ICLR = 5'd8,
                         A_OWN = 5'd12, A_SHR = 5'd16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  int          n_tests = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  ptmr_top dut_i (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic logic [31:0] ctl(bit run, int sel, bit rsel, bit lmode, bit ie, bit flg);
    return 32'(flg) << 7 | 32'(ie) << 6 | 32'(lmode) << 4 | 32'(rsel) << 3
         | 32'(sel & 3) << 1 | 32'(run);
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=0x%08h exp=0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d, bit with_ref = 1'b0);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; ref_tick = with_ref;
    @(negedge clk);
    bus_wr = 1'b0; ref_tick = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic refs(int n);
    for (int i = 0; i < n; i++) begin
      ref_tick = 1'b1; @(negedge clk);
      ref_tick = 1'b0; @(negedge clk);
    end
  endtask

  // snapshot through own address (mode 0), value read with select 0
  task automatic snap_count(output logic [31:0] v);
    logic [31:0] dummy;
    rd(A_OWN, dummy);
    rd(A_VAL, v);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_CSR, v); check("R1 csr", v, 32'h0);
    rd(A_VAL, v); check("R1 value", v, 32'h0);
    check("R1 irq", 32'(irq), 32'h0);
  endtask

  task automatic t_rates();
    logic [31:0] v;
    for (int s = 0; s < 4; s++) begin
      int dv = 2 << s;
      wr(A_CSR, ctl(0, s, 0, 0, 0, 0));
      wr(A_VAL, 32'd1000);
      wr(A_CSR, ctl(1, s, 0, 0, 0, 0));
      refs(3 * dv - 1);
      snap_count(v); check("R2 before third tick", v, 32'd998);
      refs(1);
      snap_count(v); check("R2 third tick", v, 32'd997);
    end
    wr(A_CSR, ctl(0, 0, 0, 0, 0, 0));
  endtask

  task automatic t_reload();
    logic [31:0] v;
    wr(A_CSR, ctl(0, 0, 0, 0, 1, 0));
    wr(A_VAL, 32'd3);
    wr(A_CSR, ctl(1, 0, 0, 0, 1, 0));
    refs(4);
    snap_count(v); check("R3 down to one", v, 32'd1);
    check("R7 no irq yet", 32'(irq), 32'h0);
    refs(2);
    snap_count(v); check("R3 reload", v, 32'd3);
    rd(A_CSR, v); check("R7 flag set", v >> 7 & 1, 32'h1);
    check("R7 irq high", 32'(irq), 32'h1);
    wr(A_ICLR, 32'h0);
    check("R8 iclr", 32'(irq), 32'h0);
    wr(A_CSR, ctl(0, 0, 0, 0, 1, 0));
    refs(10);
    snap_count(v); check("R3 hold when stopped", v, 32'd3);
  endtask

  task automatic t_restart_rsel();
    logic [31:0] v;
    wr(A_VAL, 32'd50);
    wr(A_CSR, ctl(1, 0, 0, 0, 0, 0));
    refs(5);
    snap_count(v); check("R4 running", v, 32'd48);
    wr(A_VAL, 32'd20);
    refs(1);
    snap_count(v); check("R4 phase cleared", v, 32'd20);
    refs(1);
    snap_count(v); check("R4 first tick", v, 32'd19);
    wr(A_CSR, ctl(1, 0, 1, 0, 0, 0));
    rd(A_VAL, v); check("R5 reload view", v, 32'd20);
    wr(A_CSR, ctl(1, 0, 0, 0, 0, 0));
    rd(A_VAL, v); check("R5 held view", v, 32'd19);
    wr(A_CSR, ctl(0, 0, 0, 0, 0, 0));
  endtask

  task automatic t_latch();
    logic [31:0] v, dummy;
    wr(A_VAL, 32'd100);
    wr(A_CSR, ctl(1, 0, 0, 0, 0, 0));
    refs(2);
    snap_count(v); check("R6 own capture", v, 32'd99);
    refs(2);
    rd(A_VAL, v); check("R6 no read capture", v, 32'd99);
    rd(A_SHR, dummy);
    rd(A_VAL, v); check("R6 shared ignored in mode 0", v, 32'd99);
    wr(A_CSR, ctl(1, 0, 0, 1, 0, 0));
    rd(A_OWN, dummy);
    rd(A_VAL, v); check("R6 own ignored in mode 1", v, 32'd99);
    rd(A_SHR, dummy);
    rd(A_VAL, v); check("R6 shared capture", v, 32'd98);
    wr(A_CSR, ctl(0, 0, 0, 0, 0, 0));
  endtask

  task automatic t_force();
    logic [31:0] v;
    wr(A_CSR, ctl(0, 0, 0, 0, 0, 1));
    rd(A_CSR, v); check("R9 forced flag", v >> 7 & 1, 32'h1);
    check("R7 masked irq", 32'(irq), 32'h0);
    wr(A_CSR, ctl(0, 0, 0, 0, 1, 1));
    check("R9 irq on enable", 32'(irq), 32'h1);
    wr(A_CSR, ctl(0, 0, 0, 0, 1, 0));
    rd(A_CSR, v); check("R8 csr clear", v >> 7 & 1, 32'h0);
    check("R8 irq low", 32'(irq), 32'h0);
    wr(A_CSR, ctl(0, 0, 0, 0, 1, 1));
    check("R9 forced irq", 32'(irq), 32'h1);
    wr(A_ICLR, 32'hFFFF_FFFF);
    repeat (10) @(negedge clk);
    check("R9 single interrupt", 32'(irq), 32'h0);
  endtask

  task automatic t_set_wins();
    logic [31:0] v;
    wr(A_CSR, ctl(0, 0, 0, 0, 1, 0));
    wr(A_VAL, 32'd1);
    wr(A_CSR, ctl(1, 0, 0, 0, 1, 0));
    refs(1);
    wr(A_ICLR, 32'h0, 1'b1);
    rd(A_CSR, v); check("R10 expiry beats clear", v >> 7 & 1, 32'h1);
    check("R10 irq", 32'(irq), 32'h1);
    wr(A_CSR, ctl(0, 0, 0, 0, 0, 0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rates();
    t_reload();
    t_restart_rsel();
    t_latch();
    t_force();
    t_set_wins();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog got=timeout exp=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule